// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a virtual address into a physical address by walking radix page tables held in memory. A request carries the virtual address, the kind of access (instruction fetch, data load or data store), the current privilege together with the machine-mode "use previous privilege" controls, the supervisor-may-touch-user-pages and make-executable-readable flags, the page number of the root table and the translation mode. The walker reads one table entry at a time over a simple request/acknowledge memory port, descends through pointer entries and checks the leaf it ends on.

Two table formats are supported: a 32-bit format with two levels of 10-bit indices and 4-byte entries, and a 39-bit format with three levels of 9-bit indices and 8-byte entries. Pages are 4 KiB. Leaves found above the last level map large pages. When a leaf's accessed bit, or for a store its dirty bit, still needs setting, the walker reads the entry again, writes it back with those bits set only if it is unchanged, and otherwise starts the whole walk over. The result is the physical address and read/write/execute rights, or a fault.

Top module: `ptw_walker`

## Requirements
- R1: When the mode is bare (req_mode 0) or the effective privilege is machine (3), the walker makes no memory access and answers with resp_paddr equal to the low PA_W bits of the virtual address and resp_r, resp_w, resp_x all 1.
- R2: For a load (req_kind 1) or store (req_kind 2) issued at privilege 3 with req_mprv set, the effective privilege is req_mpp; a fetch (req_kind 0) always uses req_priv. Privilege codes are 0 user, 1 supervisor, 3 machine.
- R3: In the 39-bit mode (req_mode 2) virtual bits 63..38 must all be equal, otherwise the walker faults without any memory access; in the 32-bit mode (req_mode 1) bits 63..32 are ignored. req_mode 3 always faults.
- R4: The first entry read is at req_root*4096 + top index * entry size, where the index is va[38:30] (39-bit) or va[31:22] (32-bit); mem_wide is 1 for 8-byte and 0 for 4-byte entries.
- R5: Entry bits are V=0, R=1, W=2, X=3, U=4, A=6, D=7, page number from bit 10. V clear faults; V set with R, W, X clear is a pointer whose page number times 4096 is the next table base; a pointer at the last level faults.
- R6: A leaf with W set and R clear (W alone, or W with X) faults.
- R7: A user page (U set) faults at supervisor privilege unless SUM is set, and always faults for a supervisor fetch; a page with U clear faults unless the effective privilege is supervisor.
- R8: A leaf at a level above the last whose page number has a nonzero bit in the positions of the levels below faults.
- R9: A load needs R, or X with MXR set; a store needs W; a fetch needs X; otherwise the walker faults.
- R10: If a valid leaf has A clear, or is a store with D clear, the walker re-reads the entry and, if it is unchanged, writes it back ORed with A and, for a store, D, using the same entry width.
- R11: If the re-read entry differs from the one walked, the walk restarts from the root table and the final result comes from the new walk.
- R12: The physical page number is the leaf page number ORed with the virtual page number bits of the levels not walked; resp_r = R or (X and MXR), resp_x = X, resp_w = W and (store or D).
- R13: A request is taken only while req_ready is high; req_ready stays low and further requests are ignored until the one-cycle resp_valid pulse; no memory request is made while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_vaddr | input | 64 | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| req_mprv | input | 1 | Data accesses at M use req_mpp |
| req_mpp | input | 2 | Previous privilege used under req_mprv |
| req_sum | input | 1 | Supervisor may access user pages |
| req_mxr | input | 1 | Executable pages readable by loads |
| req_root | input | PA_W-OFS_W | Root table page number |
| req_mode | input | 2 | 0 bare, 1 32-bit, 2 39-bit, 3 reserved |
| resp_valid | output | 1 | One-cycle result pulse |
| resp_fault | output | 1 | Translation failed |
| resp_paddr | output | PA_W | Physical address |
| resp_r | output | 1 | Read allowed |
| resp_w | output | 1 | Write allowed |
| resp_x | output | 1 | Execute allowed |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_wide | output | 1 | 1 for 8-byte, 0 for 4-byte entry |
| mem_addr | output | PA_W | Byte address of the entry |
| mem_wdata | output | 64 | Entry to write |
| mem_ack | input | 1 | Access complete, read data valid |
| mem_rdata | input | 64 | Read entry (low 32 bits for 4-byte) |

## Verification
The main sweep walks a fixed three-level 39-bit table and tries every one of the 256 values of the leaf's low flag byte against every access kind, both user and supervisor privilege and both settings of SUM and MXR; this separates the reserved encodings, the privilege rules, the per-kind rights, the last-level pointer case and exactly when an accessed/dirty write-back is due and what it writes. Directed walks in both formats then place leaves at the upper levels with aligned and misaligned page numbers to tell large-page address merging from alignment faults, vary privilege, MPRV and the upper address bits to separate pass-through, privilege substitution and the sign-extension check, and alter an entry between the first read and the re-read to force a restart. A request held high during a walk shows whether a busy walker takes a second request.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   localparam logic [1:0] ACC_FETCH = 2'd0;
   localparam logic [1:0] ACC_LOAD  = 2'd1;
   localparam logic [1:0] ACC_STORE = 2'd2;

   localparam logic [1:0] PL_USER  = 2'd0;
   localparam logic [1:0] PL_SUPER = 2'd1;
   localparam logic [1:0] PL_MACH  = 2'd3;

   localparam logic [1:0] XM_BARE  = 2'd0;
   localparam logic [1:0] XM_T32   = 2'd1;
   localparam logic [1:0] XM_T39   = 2'd2;

   // entry flag positions, fixed by the table format
   localparam int BIT_V = 0;
   localparam int BIT_R = 1;
   localparam int BIT_W = 2;
   localparam int BIT_X = 3;
   localparam int BIT_U = 4;
   localparam int BIT_A = 6;
   localparam int BIT_D = 7;
   localparam int PN_LSB = 10;

   typedef enum logic [2:0] {
      WK_IDLE,
      WK_FETCH,
      WK_JUDGE,
      WK_RECHECK,
      WK_STORE,
      WK_REPLY
   } walk_state_e;

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
   parameter int PA_W  = 56,
   parameter int OFS_W = 12,
   localparam int PN_W = PA_W - OFS_W
) (
   input  logic [PN_W-1:0] table_pn,
   input  logic [1:0]      level,
   input  logic            fmt39,
   input  logic [38:0]     vaddr,
   output logic [PA_W-1:0] entry_addr
);
   logic [4:0]  shamt;
   logic [9:0]  index;
   logic [38:0] shifted;

   always_comb begin
      shamt   = fmt39 ? 5'(9 * level) : 5'(10 * level);
      shifted = vaddr >> (OFS_W + int'(shamt));
      index   = fmt39 ? {1'b0, shifted[8:0]} : shifted[9:0];
      entry_addr = {table_pn, {OFS_W{1'b0}}} +
                   (PA_W'(index) << (fmt39 ? 3 : 2));
   end

   logic unused_hi;
   assign unused_hi = ^shifted[38:10];
endmodule

// File: rtl/ptw_leaf_judge.sv
module ptw_leaf_judge
   import ptw_pkg::*;
#(
   parameter int PA_W  = 56,
   parameter int OFS_W = 12,
   localparam int PN_W = PA_W - OFS_W
) (
   input  logic [63:0]     pte,
   input  logic [1:0]      level,
   input  logic            fmt39,
   input  logic [1:0]      kind,
   input  logic [1:0]      priv,
   input  logic            sum,
   input  logic            mxr,
   input  logic [38:0]     vaddr,
   output logic            is_ptr,
   output logic            fault,
   output logic            need_upd,
   output logic [PN_W-1:0] next_pn,
   output logic [PN_W-1:0] phys_pn,
   output logic [63:0]     upd_pte,
   output logic            perm_r,
   output logic            perm_w,
   output logic            perm_x
);
   logic v, r, w, x, u, a, d, leaf, is_store, is_fetch;
   logic [4:0]      shamt;
   logic [PN_W-1:0] low_mask, vpn;
   logic bad_enc, bad_user, bad_super, bad_align, bad_perm;

   always_comb begin
      v = pte[BIT_V]; r = pte[BIT_R]; w = pte[BIT_W]; x = pte[BIT_X];
      u = pte[BIT_U]; a = pte[BIT_A]; d = pte[BIT_D];
      is_store = (kind == ACC_STORE);
      is_fetch = (kind == ACC_FETCH);
      next_pn  = fmt39 ? PN_W'(pte[53:PN_LSB]) : PN_W'(pte[31:PN_LSB]);
      vpn      = fmt39 ? PN_W'(vaddr[38:OFS_W]) : PN_W'(vaddr[31:OFS_W]);
      shamt    = fmt39 ? 5'(9 * level) : 5'(10 * level);
      low_mask = (PN_W'(1) << shamt) - PN_W'(1);

      leaf      = v & (r | w | x);
      is_ptr    = v & ~(r | w | x) & (level != 2'd0);
      bad_enc   = w & ~r;
      bad_user  = u & (priv != PL_USER) & (~sum | is_fetch);
      bad_super = ~u & (priv != PL_SUPER);
      bad_align = |(next_pn & low_mask);
      case (kind)
         ACC_LOAD:  bad_perm = ~(r | (x & mxr));
         ACC_STORE: bad_perm = ~w;
         default:   bad_perm = ~x;
      endcase

      fault    = ~v | (~leaf & ~is_ptr) |
                 (leaf & (bad_enc | bad_user | bad_super | bad_align | bad_perm));
      need_upd = ~a | (is_store & ~d);
      upd_pte  = pte;
      upd_pte[BIT_A] = 1'b1;
      if (is_store) upd_pte[BIT_D] = 1'b1;

      phys_pn = next_pn | (vpn & low_mask);
      perm_r  = r | (x & mxr);
      perm_w  = w & (is_store | d);
      perm_x  = x;
   end

   logic unused_bits;
   assign unused_bits = ^{pte[63:54], pte[9:8], pte[5]};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int PA_W    = 56,
   parameter int OFS_W   = 12,
   parameter bit SV39_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [63:0]           req_vaddr,
   input  logic [1:0]            req_kind,
   input  logic [1:0]            req_priv,
   input  logic                  req_mprv,
   input  logic [1:0]            req_mpp,
   input  logic                  req_sum,
   input  logic                  req_mxr,
   input  logic [PA_W-OFS_W-1:0] req_root,
   input  logic [1:0]            req_mode,
   output logic                  resp_valid,
   output logic                  resp_fault,
   output logic [PA_W-1:0]       resp_paddr,
   output logic                  resp_r,
   output logic                  resp_w,
   output logic                  resp_x,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic                  mem_wide,
   output logic [PA_W-1:0]       mem_addr,
   output logic [63:0]           mem_wdata,
   input  logic                  mem_ack,
   input  logic [63:0]           mem_rdata
);
   localparam int PN_W = PA_W - OFS_W;

   initial begin
      if (PA_W < 34 || PA_W > 56 || OFS_W != 12)
         $error("ptw_walker: unsupported address configuration");
   end

   walk_state_e st;
   logic [38:0]     r_va;
   logic [1:0]      r_kind, r_priv, r_lvl;
   logic            r_sum, r_mxr, r_fmt39;
   logic [PN_W-1:0] r_root, r_base;
   logic [63:0]     r_pte;
   logic            r_fault, r_r, r_w, r_x;
   logic [PA_W-1:0] r_paddr;

   // effective privilege and address-form check at request time
   logic [1:0] eff_priv;
   logic       fmt_ok;
   assign eff_priv = (req_priv == PL_MACH && req_kind != ACC_FETCH && req_mprv)
                     ? req_mpp : req_priv;

   if (SV39_EN) begin : g_fmt39
      assign fmt_ok = (req_mode == XM_T32) ||
                      (req_mode == XM_T39 &&
                       ((&req_vaddr[63:38]) || !(|req_vaddr[63:38])));
   end else begin : g_fmt32_only
      logic unused_va;
      assign unused_va = ^req_vaddr[63:39];
      assign fmt_ok = (req_mode == XM_T32);
   end

   logic [PA_W-1:0] ent_addr;
   ptw_entry_addr #(.PA_W(PA_W), .OFS_W(OFS_W)) u_addr (
      .table_pn(r_base), .level(r_lvl), .fmt39(r_fmt39), .vaddr(r_va),
      .entry_addr(ent_addr)
   );

   logic            j_ptr, j_fault, j_upd, j_r, j_w, j_x;
   logic [PN_W-1:0] j_next, j_phys;
   logic [63:0]     j_upd_pte;
   ptw_leaf_judge #(.PA_W(PA_W), .OFS_W(OFS_W)) u_judge (
      .pte(r_pte), .level(r_lvl), .fmt39(r_fmt39), .kind(r_kind),
      .priv(r_priv), .sum(r_sum), .mxr(r_mxr), .vaddr(r_va),
      .is_ptr(j_ptr), .fault(j_fault), .need_upd(j_upd),
      .next_pn(j_next), .phys_pn(j_phys), .upd_pte(j_upd_pte),
      .perm_r(j_r), .perm_w(j_w), .perm_x(j_x)
   );

   logic [63:0] rd_pte;
   assign rd_pte = r_fmt39 ? mem_rdata : {32'd0, mem_rdata[31:0]};

   assign req_ready  = (st == WK_IDLE);
   assign resp_valid = (st == WK_REPLY);
   assign resp_fault = r_fault;
   assign resp_paddr = r_paddr;
   assign resp_r     = r_r;
   assign resp_w     = r_w;
   assign resp_x     = r_x;
   assign mem_req    = (st == WK_FETCH) || (st == WK_RECHECK) || (st == WK_STORE);
   assign mem_we     = (st == WK_STORE);
   assign mem_wide   = r_fmt39;
   assign mem_addr   = ent_addr;
   assign mem_wdata  = j_upd_pte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= WK_IDLE;
         r_va <= '0; r_kind <= '0; r_priv <= '0; r_lvl <= '0;
         r_sum <= 1'b0; r_mxr <= 1'b0; r_fmt39 <= 1'b0;
         r_root <= '0; r_base <= '0; r_pte <= '0;
         r_fault <= 1'b0; r_r <= 1'b0; r_w <= 1'b0; r_x <= 1'b0;
         r_paddr <= '0;
      end else begin
         case (st)
            WK_IDLE: if (req_valid) begin
               r_va    <= req_vaddr[38:0];
               r_kind  <= req_kind;
               r_priv  <= eff_priv;
               r_sum   <= req_sum;
               r_mxr   <= req_mxr;
               r_fmt39 <= (req_mode == XM_T39);
               r_root  <= req_root;
               r_base  <= req_root;
               r_lvl   <= (req_mode == XM_T39) ? 2'd2 : 2'd1;
               r_paddr <= '0;
               {r_r, r_w, r_x} <= 3'b000;
               r_fault <= 1'b0;
               if (req_mode == XM_BARE || eff_priv == PL_MACH) begin
                  r_paddr <= req_vaddr[PA_W-1:0];
                  {r_r, r_w, r_x} <= 3'b111;
                  st <= WK_REPLY;
               end else if (!fmt_ok) begin
                  r_fault <= 1'b1;
                  st <= WK_REPLY;
               end else begin
                  st <= WK_FETCH;
               end
            end
            WK_FETCH: if (mem_ack) begin
               r_pte <= rd_pte;
               st    <= WK_JUDGE;
            end
            WK_JUDGE: begin
               if (j_fault) begin
                  r_fault <= 1'b1;
                  st <= WK_REPLY;
               end else if (j_ptr) begin
                  r_base <= j_next;
                  r_lvl  <= r_lvl - 2'd1;
                  st <= WK_FETCH;
               end else if (j_upd) begin
                  st <= WK_RECHECK;
               end else begin
                  r_paddr <= {j_phys, r_va[OFS_W-1:0]};
                  {r_r, r_w, r_x} <= {j_r, j_w, j_x};
                  st <= WK_REPLY;
               end
            end
            WK_RECHECK: if (mem_ack) begin
               if (rd_pte == r_pte) begin
                  st <= WK_STORE;
               end else begin
                  r_base <= r_root;
                  r_lvl  <= r_fmt39 ? 2'd2 : 2'd1;
                  st <= WK_FETCH;
               end
            end
            WK_STORE: if (mem_ack) begin
               r_paddr <= {j_phys, r_va[OFS_W-1:0]};
               {r_r, r_w, r_x} <= {j_r, j_w, j_x};
               st <= WK_REPLY;
            end
            default: st <= WK_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
   parameter int PA_W  = 56,
   parameter int OFS_W = 12
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic [63:0]     req_vaddr,
   input logic [1:0]      req_kind,
   input logic [1:0]      req_priv,
   input logic [1:0]      req_mode,
   input logic            resp_valid,
   input logic            resp_fault,
   input logic [PA_W-1:0] resp_paddr,
   input logic            resp_r,
   input logic            resp_w,
   input logic            resp_x,
   input logic            mem_req,
   input logic            mem_we,
   input logic [PA_W-1:0] mem_addr,
   input logic [63:0]     mem_wdata,
   input logic            mem_ack
);
   logic [1:0] c_kind;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) c_kind <= 2'd0;
      else if (req_valid && req_ready) c_kind <= req_kind;
   end

   logic noncanon;
   assign noncanon = !((&req_vaddr[63:38]) || !(|req_vaddr[63:38]));

   // R1
   bare_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && req_mode == 2'd0 |=>
         resp_valid && !resp_fault && resp_r && resp_w && resp_x &&
         resp_paddr == $past(req_vaddr[PA_W-1:0]));

   // R3
   noncanon_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && req_mode == 2'd2 && req_priv == 2'd0 && noncanon |=>
         resp_valid && resp_fault);

   // R4
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   // R9
   kind_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && !resp_fault |->
         (c_kind == 2'd1 ? resp_r : (c_kind == 2'd2 ? resp_w : resp_x)));

   // R10
   wb_sets_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_wdata[6] && mem_wdata[0]);

   // R13
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req && !resp_valid);

   // R13
   pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W), .OFS_W(OFS_W)) u_walker_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_vaddr(req_vaddr), .req_kind(req_kind), .req_priv(req_priv),
   .req_mode(req_mode), .resp_valid(resp_valid), .resp_fault(resp_fault),
   .resp_paddr(resp_paddr), .resp_r(resp_r), .resp_w(resp_w), .resp_x(resp_x),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
   .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;
   localparam int PA_W = 56;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        req_valid = 1'b0, req_ready;
   logic [63:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0, req_priv = '0, req_mpp = '0, req_mode = '0;
   logic        req_mprv = 1'b0, req_sum = 1'b0, req_mxr = 1'b0;
   logic [43:0] req_root = '0;
   logic        resp_valid, resp_fault, resp_r, resp_w, resp_x;
   logic [PA_W-1:0] resp_paddr;
   logic        mem_req, mem_we, mem_wide;
   logic [PA_W-1:0] mem_addr;
   logic [63:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [63:0] mem_rdata = '0;

   ptw_walker dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_kind(req_kind), .req_priv(req_priv),
      .req_mprv(req_mprv), .req_mpp(req_mpp), .req_sum(req_sum),
      .req_mxr(req_mxr), .req_root(req_root), .req_mode(req_mode),
      .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_paddr(resp_paddr),
      .resp_r(resp_r), .resp_w(resp_w), .resp_x(resp_x),
      .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   // memory model: 32-bit words, one-cycle acknowledge
   logic [31:0] mem [0:8191];
   int          rd_cnt = 0, wr_cnt = 0, resp_cnt = 0;
   logic [55:0] raddr_log [0:7];
   logic        rwide_log [0:7];
   logic [63:0] last_wdata = '0;
   logic        last_wwide = 1'b0;
   logic        clob_arm = 1'b0;
   logic [55:0] clob_addr = '0;
   logic [63:0] clob_val = '0;

   always @(posedge clk) begin
      int i;
      if (!rst_n) mem_ack <= 1'b0;
      else if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         i = int'(mem_addr[14:2]);
         if (mem_we) begin
            mem[i] = mem_wdata[31:0];
            if (mem_wide) mem[i+1] = mem_wdata[63:32];
            wr_cnt++;
            last_wdata = mem_wdata;
            last_wwide = mem_wide;
         end else begin
            mem_rdata <= mem_wide ? {mem[i+1], mem[i]} : {32'd0, mem[i]};
            if (rd_cnt < 8) begin
               raddr_log[rd_cnt] = mem_addr;
               rwide_log[rd_cnt] = mem_wide;
            end
            rd_cnt++;
            if (clob_arm && mem_addr == clob_addr) begin
               mem[i] = clob_val[31:0];
               if (mem_wide) mem[i+1] = clob_val[63:32];
               clob_arm = 1'b0;
            end
         end
      end else mem_ack <= 1'b0;
   end

   always @(posedge clk) if (resp_valid) resp_cnt++;

   int checks = 0, errors = 0;
   bit timed_out = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic put64(input logic [55:0] a, input logic [63:0] v);
      mem[int'(a[14:2])]   = v[31:0];
      mem[int'(a[14:2])+1] = v[63:32];
   endtask

   task automatic put32(input logic [55:0] a, input logic [31:0] v);
      mem[int'(a[14:2])] = v;
   endtask

   task automatic run(input logic [63:0] va, input logic [1:0] kind,
                      input logic [1:0] priv, input logic mprv,
                      input logic [1:0] mpp, input logic sum, input logic mxr,
                      input logic [43:0] root, input logic [1:0] mode);
      int n;
      @(negedge clk);
      rd_cnt = 0; wr_cnt = 0;
      req_vaddr = va; req_kind = kind; req_priv = priv; req_mprv = mprv;
      req_mpp = mpp; req_sum = sum; req_mxr = mxr; req_root = root;
      req_mode = mode; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!resp_valid && n < 200) begin
         @(negedge clk);
         n++;
      end
      if (n >= 200) chk(1'b0, "R13", "no response", 64'd0, 64'd1);
   endtask

   // 39-bit table set: root page 1, level-1 page 2, leaf page 3
   localparam logic [63:0] VA39   = 64'h0000_0000_4040_3ABC;
   localparam logic [43:0] LEAFPN = 44'h00ABCD5;
   localparam logic [55:0] A39_L2 = 56'h1008;
   localparam logic [55:0] A39_L1 = 56'h2010;
   localparam logic [55:0] A39_L0 = 56'h3018;

   task automatic tables39(input logic [7:0] flags);
      put64(A39_L2, (64'd2 << 10) | 64'h1);
      put64(A39_L1, (64'd3 << 10) | 64'h1);
      put64(A39_L0, (64'(LEAFPN) << 10) | 64'(flags));
   endtask

   initial begin
      fork
         begin : main_seq
            for (int k = 0; k < 8192; k++) mem[k] = 32'd0;
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            // R13: reset state
            chk(req_ready == 1'b1, "R13", "ready after reset", 64'(req_ready), 64'd1);
            chk(resp_valid == 1'b0 && mem_req == 1'b0, "R13", "quiet after reset",
                64'({resp_valid, mem_req}), 64'd0);

            // R5/R6/R7/R9/R10/R12 sweep over all leaf flag bytes
            for (int fl = 0; fl < 256; fl++) begin
               for (int kd = 0; kd < 3; kd++) begin
                  for (int pv = 0; pv < 2; pv++) begin
                     for (int sm = 0; sm < 2; sm++) begin
                        for (int mx = 0; mx < 2; mx++) begin
                           bit v, r, w, x, u, a, d, ef, eu;
                           logic [63:0] pte, wexp;
                           v = fl[0]; r = fl[1]; w = fl[2]; x = fl[3];
                           u = fl[4]; a = fl[6]; d = fl[7];
                           ef = !v || (!r && !w && !x) || (w && !r) ||
                                (u && pv != 0 && (sm == 0 || kd == 0)) ||
                                (!u && pv != 1) ||
                                (kd == 1 && !(r || (x && mx == 1))) ||
                                (kd == 2 && !w) || (kd == 0 && !x);
                           eu = !ef && (!a || (kd == 2 && !d));
                           pte  = (64'(LEAFPN) << 10) | 64'(fl);
                           wexp = pte | 64'h40 | ((kd == 2) ? 64'h80 : 64'h0);
                           tables39(8'(fl));
                           run(VA39, 2'(kd), 2'(pv), 1'b0, 2'd0, 1'(sm), 1'(mx),
                               44'd1, 2'd2);
                           chk(resp_fault == ef, "R5/R6/R7/R9", "sweep fault",
                               64'(resp_fault), 64'(ef));
                           if (!ef) begin
                              chk(resp_paddr == {LEAFPN, 12'hABC}, "R12", "sweep paddr",
                                  64'(resp_paddr), 64'({LEAFPN, 12'hABC}));
                              chk({resp_r, resp_w, resp_x} ==
                                  {r || (x && mx == 1), w && (kd == 2 || d), x},
                                  "R12", "sweep rights", 64'({resp_r, resp_w, resp_x}),
                                  64'({r || (x && mx == 1), w && (kd == 2 || d), x}));
                           end
                           chk(wr_cnt == (eu ? 1 : 0), "R10", "writeback count",
                               64'(wr_cnt), 64'(eu));
                           if (eu) chk(last_wdata == wexp && last_wwide, "R10",
                                       "writeback data", last_wdata, wexp);
                        end
                     end
                  end
               end
            end

            // R4: entry addresses of a full 39-bit walk
            tables39(8'hCF);
            run(VA39, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 44'd1, 2'd2);
            chk(rd_cnt == 3, "R4", "reads", 64'(rd_cnt), 64'd3);
            chk(raddr_log[0] == A39_L2 && rwide_log[0], "R4", "first entry addr",
                64'(raddr_log[0]), 64'(A39_L2));
            chk(raddr_log[1] == A39_L1 && raddr_log[2] == A39_L0, "R4/R5", "next entry addrs",
                64'(raddr_log[2]), 64'(A39_L0));

            // R1: bare and machine privilege
            run(64'hFFFF_1234_5678_9ABC, 2'd2, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 44'd1, 2'd0);
            chk(!resp_fault && resp_paddr == 56'hFF_1234_5678_9ABC && rd_cnt == 0,
                "R1", "bare pass", 64'(resp_paddr), 64'h00FF_1234_5678_9ABC);
            run(64'h0000_00AB_CDEF_0123, 2'd0, 2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 44'd1, 2'd2);
            chk(!resp_fault && resp_paddr == 56'hAB_CDEF_0123 &&
                {resp_r, resp_w, resp_x} == 3'b111 && rd_cnt == 0,
                "R1", "machine pass", 64'(resp_paddr), 64'hAB_CDEF_0123);

            // R2: MPRV substitution
            run(VA39, 2'd1, 2'd3, 1'b1, 2'd1, 1'b0, 1'b0, 44'd1, 2'd2);
            chk(!resp_fault && rd_cnt == 3, "R2", "mprv as S walks",
                64'(rd_cnt), 64'd3);
            run(VA39, 2'd1, 2'd3, 1'b1, 2'd0, 1'b0, 1'b0, 44'd1, 2'd2);
            chk(resp_fault == 1'b1, "R2", "mprv as U on S page",
                64'(resp_fault), 64'd1);
            run(VA39, 2'd0, 2'd3, 1'b1, 2'd0, 1'b0, 1'b0, 44'd1, 2'd2);
            chk(!resp_fault && rd_cnt == 0 && resp_paddr == 56'(VA39), "R2",
                "fetch ignores mprv", 64'(rd_cnt), 64'd0);

            // R3: upper address form
            run(64'h8000_0000_4040_3ABC, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 44'd1, 2'd2);
            chk(resp_fault && rd_cnt == 0, "R3", "noncanonical",
                64'(rd_cnt), 64'd0);
            run(64'hFFFF_FFC0_0000_0000, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 44'd1, 2'd2);
            chk(rd_cnt == 1 && raddr_log[0] == 56'h1800, "R3", "negative canonical walks",
                64'(raddr_log[0]), 64'h1800);
            run(64'd0, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 44'd1, 2'd3);
            chk(resp_fault && rd_cnt == 0, "R3", "reserved mode", 64'(resp_fault), 64'd1);

            // 32-bit format: root page 4, leaf page 5
            put32(56'h4014, (32'd5 << 10) | 32'h1);
            put32(56'h5018, (32'h2ABCD << 10) | 32'hCF);
            run(64'hDEAD_BEEF_0140_6123, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 44'd4, 2'd1);
            chk(!resp_fault && resp_paddr == 56'h2ABCD123, "R3/R12", "t32 walk",
                64'(resp_paddr), 64'h2ABCD123);
            chk(rd_cnt == 2 && raddr_log[0] == 56'h4014 && !rwide_log[0], "R4",
                "t32 first entry", 64'(raddr_log[0]), 64'h4014);
            put32(56'h5018, (32'h2ABCD << 10) | 32'h0F);
            run(64'h0000_0000_0140_6123, 2'd2, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 44'd4, 2'd1);
            chk(wr_cnt == 1 && rd_cnt == 3 && !last_wwide &&
                last_wdata[31:0] == ((32'h2ABCD << 10) | 32'hCF), "R10",
                "t32 writeback", last_wdata, 64'((32'h2ABCD << 10) | 32'hCF));

            // R8/R12: 32-bit large page
            put32(56'h4014, (32'hC00 << 10) | 32'hCF);
            run(64'h0000_0000_0140_6123, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 44'd4, 2'd1);
            chk(!resp_fault && resp_paddr == 56'hC06123 && rd_cnt == 1, "R12",
                "t32 large page", 64'(resp_paddr), 64'hC06123);
            put32(56'h4014, (32'hC01 << 10) | 32'hCF);
            run(64'h0000_0000_0140_6123, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 44'd4, 2'd1);
            chk(resp_fault == 1'b1, "R8", "t32 misaligned", 64'(resp_fault), 64'd1);

            // R8/R12: 39-bit 2 MiB and 1 GiB pages
            tables39(8'hCF);
            put64(A39_L1, (64'h200 << 10) | 64'hCF);
            run(VA39, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 44'd1, 2'd2);
            chk(!resp_fault && resp_paddr == 56'h203ABC && rd_cnt == 2, "R12",
                "2M page", 64'(resp_paddr), 64'h203ABC);
            put64(A39_L1, (64'h201 << 10) | 64'hCF);
            run(VA39, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 44'd1, 2'd2);
            chk(resp_fault == 1'b1, "R8", "2M misaligned", 64'(resp_fault), 64'd1);
            put64(A39_L2, (64'h40000 << 10) | 64'hCF);
            run(VA39, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 44'd1, 2'd2);
            chk(!resp_fault && resp_paddr == 56'h4040_3ABC && rd_cnt == 1, "R12",
                "1G page", 64'(resp_paddr), 64'h4040_3ABC);
            put64(A39_L2, (64'h40100 << 10) | 64'hCF);
            run(VA39, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 44'd1, 2'd2);
            chk(resp_fault == 1'b1, "R8", "1G misaligned", 64'(resp_fault), 64'd1);

            // R11: entry changes between read and re-read
            tables39(8'h0F);
            clob_addr = A39_L0;
            clob_val  = (64'h11111 << 10) | 64'hCF;
            clob_arm  = 1'b1;
            run(VA39, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 44'd1, 2'd2);
            chk(!resp_fault && resp_paddr == 56'h1111_1ABC, "R11", "restart result",
                64'(resp_paddr), 64'h1111_1ABC);
            chk(rd_cnt == 7 && wr_cnt == 0, "R11", "restart accesses",
                64'(rd_cnt), 64'd7);

            // R13: request held during a walk is ignored
            begin
               int base_cnt, n;
               bit busy_bad;
               tables39(8'hCF);
               busy_bad = 1'b0;
               @(negedge clk);
               base_cnt = resp_cnt;
               req_vaddr = VA39; req_kind = 2'd1; req_priv = 2'd1; req_mprv = 1'b0;
               req_root = 44'd1; req_mode = 2'd2; req_valid = 1'b1;
               @(negedge clk);
               req_mode = 2'd0; req_vaddr = 64'h1234;
               n = 0;
               while (!resp_valid && n < 200) begin
                  if (req_ready) busy_bad = 1'b1;
                  @(negedge clk);
                  n++;
               end
               req_valid = 1'b0;
               chk(!busy_bad, "R13", "ready low while busy", 64'(busy_bad), 64'd0);
               chk(!resp_fault && resp_paddr == {LEAFPN, 12'hABC}, "R13",
                   "first request answered", 64'(resp_paddr), 64'({LEAFPN, 12'hABC}));
               repeat (4) @(negedge clk);
               chk(resp_cnt - base_cnt == 1, "R13", "single response",
                   64'(resp_cnt - base_cnt), 64'd1);
            end
         end
         begin : watchdog
            #(5.0 * 190000);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         checks++;
         errors++;
         $display("FAIL R13 watchdog expired actual=running expected=done");
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule